// File: doc/BRIEF.md
# Rollover Timer with Trigger Clear

A sixteen-bit up-counter that advances on a one-cycle count tick. The host reads and writes the count one byte at a time. When the count passes from its all-ones value back to zero, a sticky rollover flag is set. The flag reaches the interrupt line only when a chain of enables is open: the run bit, a local interrupt enable, a peripheral-group enable and a global enable.

An external compare-trigger pulse clears the count without touching the flag. This lets a compare unit outside the block use its match value as the timer period. A sleep input freezes counting unless the timer is in asynchronous mode. A rollover that happens during sleep produces a one-cycle wake pulse. The wake pulse needs only the local and peripheral enables; the global enable does not gate it.

Top module: `rollover_timer`

## Requirements
- R1: With the run bit set, each cycle with `tick` high and no count write and no trigger adds one to the count. The count goes from 0xFFFF to 0x0000.
- R2: Every step from 0xFFFF to 0x0000 caused by a tick sets the rollover flag. The flag is bit 0 of the status register at address 3.
- R3: `irq` is high exactly when all of these are 1: the flag, run (control bit 0), local enable (control bit 2), peripheral enable (control bit 3) and global enable (control bit 4). It follows them with no register delay.
- R4: The flag stays set until the host writes address 3 with bit 0 equal to 0. Writing 1 there has no effect. If a rollover and a clearing write fall in the same cycle, the flag ends up set.
- R5: A `trig` pulse clears the count to 0x0000 and never sets the flag, even when it coincides with a tick at 0xFFFF.
- R6: A host write to address 0 (low byte) or address 1 (high byte) loads only that byte. In that cycle the other byte is unchanged, a simultaneous trigger is ignored and the tick does not advance the count.
- R7: While `sleep` is high, ticks advance the count only when asynchronous mode (control bit 1) is set.
- R8: A rollover while `sleep` is high with local and peripheral enables set raises `wake` for exactly the one cycle after the rollover edge. The global enable does not gate it.
- R9: Reset clears the count, the flag, every control bit and `wake`.
- R10: `rd_data` shows the register at `rd_addr` with no register delay: 0 count low, 1 count high, 2 control in bits 4:0, 3 flag in bit 0. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle count enable |
| trig | input | 1 | Compare-trigger pulse that clears the count |
| sleep | input | 1 | Sleep state of the surrounding system |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 2 | Host read register address |
| rd_data | output | 8 | Read data for `rd_addr` |
| irq | output | 1 | Gated rollover interrupt level |
| wake | output | 1 | One-cycle wake pulse on rollover during sleep |

## Verification
Two pairs of functions can fall in the same cycle. A host byte write can coincide with a compare trigger and a tick. A hardware rollover can coincide with a host write that clears the flag. The bench provokes each pair on purpose: it drives the write, trigger and tick in one cycle, and it preloads 0xFFFF before issuing a tick together with a flag-clear write. It then judges the outcome from the byte values and the flag read back. A long random phase brings the same overlaps about by chance. There, a behavioural model is compared with the count, flag, `irq` and `wake` on every cycle.

// File: rtl/rollover_timer.sv
module rollover_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trig,
  input  logic              sleep,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  output logic              wake
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int CTL_W = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             flag_q;
  logic             wake_q;

  wire ctl_run   = ctrl_q[0];
  wire ctl_async = ctrl_q[1];
  wire ctl_lie   = ctrl_q[2];
  wire ctl_pe    = ctrl_q[3];
  wire ctl_ge    = ctrl_q[4];

  wire wr_lo  = wr_en && (wr_addr == 2'd0);
  wire wr_hi  = wr_en && (wr_addr == 2'd1);
  wire wr_ctl = wr_en && (wr_addr == 2'd2);
  wire wr_sts = wr_en && (wr_addr == 2'd3);
  wire cnt_wr = wr_lo || wr_hi;

  wire may_count = ctl_run && (!sleep || ctl_async);
  wire advance   = tick && may_count && !cnt_wr && !trig;
  wire wrap      = advance && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_lo) cnt_q[BYTE_W-1:0] <= wr_data;
      if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data;
    end else if (trig) begin
      cnt_q <= '0;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctl) begin
      ctrl_q <= wr_data[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wrap) begin
      flag_q <= 1'b1;
    end else if (wr_sts && !wr_data[0]) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wrap && sleep && ctl_lie && ctl_pe;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      2'd0: rd_data = cnt_q[BYTE_W-1:0];
      2'd1: rd_data = cnt_q[CNT_W-1:BYTE_W];
      2'd2: rd_data[CTL_W-1:0] = ctrl_q;
      2'd3: rd_data[0] = flag_q;
      default: rd_data = '0;
    endcase
  end

  assign irq  = flag_q && ctl_run && ctl_lie && ctl_pe && ctl_ge;
  assign wake = wake_q;
endmodule

// File: rtl/rollover_timer_chk.sv
module rollover_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             sleep,
  input logic             cnt_wr,
  input logic [4:0]       ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             irq,
  input logic             wake
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && !$past(cnt_wr) && !$past(trig)) |-> (cnt == $past(cnt) + 1'b1));

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == MAXV && cnt == '0 && !$past(cnt_wr) && !$past(trig)) |-> flag);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ctrl[0] && ctrl[2] && ctrl[3] && ctrl[4]));

  p_trig_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_wr) |=> (cnt == '0));

  p_trig_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_wr && !flag) |=> !flag);

  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !ctrl[1] && !cnt_wr && !trig) |=> $stable(cnt));

  p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(sleep) && $past(cnt) == MAXV && cnt == '0));
endmodule

bind rollover_timer rollover_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .trig   (trig),
  .sleep  (sleep),
  .cnt_wr (cnt_wr),
  .ctrl   (ctrl_q),
  .cnt    (cnt_q),
  .flag   (flag_q),
  .irq    (irq),
  .wake   (wake)
);

// File: tb/rollover_timer_tb.sv
`timescale 1ns/1ps
module rollover_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, trig = 1'b0, sleep = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq, wake;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0, m_ctrl = 0;
  bit m_flag = 0, m_wake = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rollover_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .sleep(sleep),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_flag = 0; m_wake = 0;
    end else begin
      bit cw, adv, wr;
      cw  = wr_en && wr_addr < 2;
      adv = tick && m_ctrl[0] && (!sleep || m_ctrl[1]) && !cw && !trig;
      wr  = adv && m_cnt == 65535;
      m_wake = wr && sleep && m_ctrl[2] && m_ctrl[3];
      if (cw) begin
        if (wr_addr == 0) m_cnt = (m_cnt / 256) * 256 + wr_data;
        else              m_cnt = wr_data * 256 + m_cnt % 256;
      end else if (trig) m_cnt = 0;
      else if (adv) m_cnt = (m_cnt + 1) % 65536;
      if (wr) m_flag = 1;
      else if (wr_en && wr_addr == 3 && !wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 2) m_ctrl = wr_data % 32;
    end
  end

  function automatic int model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt % 256;
      2'd1: return m_cnt / 256;
      2'd2: return m_ctrl;
      default: return m_flag;
    endcase
  endfunction

  function automatic bit model_irq();
    return m_flag && m_ctrl[0] && m_ctrl[2] && m_ctrl[3] && m_ctrl[4];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) rd_addr <= rd_addr + 2'd1;

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(rd_data == 8'(model_read(rd_addr)),
            rd_addr < 2 ? "R1 count" : (rd_addr == 2 ? "R10 control" : "R4 flag"),
            rd_data, model_read(rd_addr));
      check(irq == model_irq(), "R3 irq", irq, model_irq());
      check(wake == m_wake, "R8 wake", wake, m_wake);
    end
  end

  task automatic drive(input logic tk, input logic tr, input logic we,
                       input logic [1:0] wa, input logic [7:0] wd);
    @(negedge clk);
    tick = tk; trig = tr; wr_en = we; wr_addr = wa; wr_data = wd;
  endtask

  task automatic idle(); drive(0, 0, 0, 2'd0, 8'h00); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d); drive(0, 0, 1, a, d); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) drive(1, 0, 0, 2'd0, 8'h00); endtask

  task automatic chk_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
    idle();
    for (int i = 0; i < 5; i++) begin
      #2;
      if (rd_addr == a) begin
        check(rd_data == exp, req, rd_data, exp);
        return;
      end
      @(negedge clk);
    end
    check(0, req, 0, exp);
  endtask

  task automatic chk_pins(input logic irq_e, input logic wake_e, input string req);
    #2;
    check(irq == irq_e, req, irq, irq_e);
    check(wake == wake_e, req, wake, wake_e);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk_reg(0, 8'h00, "R9 low"); chk_reg(1, 8'h00, "R9 high");
    chk_reg(2, 8'h00, "R9 ctrl"); chk_reg(3, 8'h00, "R9 flag");
    // R1 counting
    wr(2, 8'h01); ticks(5);
    chk_reg(0, 8'h05, "R1 five ticks");
    // R1/R2 wrap
    wr(0, 8'hFE); wr(1, 8'hFF); ticks(2);
    chk_reg(0, 8'h00, "R1 wrap low"); chk_reg(1, 8'h00, "R1 wrap high");
    chk_reg(3, 8'h01, "R2 flag set");
    chk_pins(0, 0, "R3 enables closed");
    // R3 enable chain
    wr(2, 8'h1D); idle(); chk_pins(1, 0, "R3 all open");
    wr(2, 8'h0D); idle(); chk_pins(0, 0, "R3 global closed");
    wr(2, 8'h1D);
    // R4 flag clear rules
    wr(3, 8'h01); chk_reg(3, 8'h01, "R4 write one ignored");
    wr(3, 8'h00); chk_reg(3, 8'h00, "R4 clear");
    wr(0, 8'hFF); wr(1, 8'hFF);
    drive(1, 0, 1, 2'd3, 8'h00);
    chk_reg(3, 8'h01, "R4 set beats clear");
    chk_reg(1, 8'h00, "R1 wrap with clear");
    wr(3, 8'h00);
    // R5 trigger
    ticks(3); drive(0, 1, 0, 2'd0, 8'h00);
    chk_reg(0, 8'h00, "R5 trig clears");
    wr(0, 8'hFF); wr(1, 8'hFF); drive(1, 1, 0, 2'd0, 8'h00);
    chk_reg(0, 8'h00, "R5 trig at max"); chk_reg(3, 8'h00, "R5 no flag");
    // R6 write beats trigger and tick
    wr(0, 8'h34); wr(1, 8'h12);
    drive(1, 1, 1, 2'd0, 8'h77);
    chk_reg(0, 8'h77, "R6 low written"); chk_reg(1, 8'h12, "R6 high kept");
    // R7 sleep
    drive(0, 0, 0, 2'd0, 8'h00); sleep = 1'b1;
    ticks(4); chk_reg(0, 8'h77, "R7 sync frozen");
    wr(2, 8'h1F); ticks(2); chk_reg(0, 8'h79, "R7 async counts");
    // R8 wake with global enable clear
    wr(2, 8'h0F); wr(0, 8'hFF); wr(1, 8'hFF);
    drive(1, 0, 0, 2'd0, 8'h00);
    idle(); chk_pins(0, 1, "R8 wake pulse");
    idle(); chk_pins(0, 0, "R8 wake ends");
    sleep = 1'b0;
    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk_reg(2, 8'h00, "R9 ctrl after reset"); chk_reg(3, 8'h00, "R9 flag after reset");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      @(negedge clk);
      tick = ($urandom_range(0, 3) != 0);
      trig = ($urandom_range(0, 40) == 0);
      if (i % 97 == 0) sleep = ~sleep;
      wr_en = (r < 8);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = (wr_addr < 2 && r < 4) ? 8'hFF : 8'($urandom_range(0, 255));
      if (wr_en && wr_addr == 2) wr_data[0] = 1'b1;
    end
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule